// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and mode flags of a small 8-bit CPU core: carry, zero, interrupt disable, decimal, break, index-X mode, overflow and negative. Each cycle, the decoder presents one operation class through a strobe and a select code. The block then updates the affected flags from the ALU result and flags, from a memory operand, from a byte pulled off the stack, or from an explicit set or clear command. Any interrupt entry forces the interrupt-disable flag high. The interrupt mask output follows that flag.

The block also forms the status byte that the core pushes onto the stack on interrupt entry. Inside the register the break flag always reads 0. Only the pushed copy carries a 1 in that bit, and only when the entry comes from a BRK instruction. A parameter selects how the pushed byte is delivered. It can be formed combinationally in the entry cycle, or it can be captured at the entry edge and held in a register. A second parameter can remove the index-X mode flag entirely.

Top module: `psr_flags`

## Requirements
- R1: After reset the flag byte reads 0x04: interrupt disable is 1 and all other flags are 0. Bit layout from bit 7 down to bit 0 is N, V, T, B, D, I, Z, C, and irq_mask reads 1.
- R2: Arithmetic class (op 1) loads C from alu_carry and V from alu_ovf. Z is set when alu_result is zero. N takes alu_result bit 7. I, D and T keep their values.
- R3: Transfer class (op 2) loads Z and N from alu_result. C and V keep their values.
- R4: Shift/rotate class (op 3) loads C from alu_carry and loads Z and N from alu_result. V keeps its value.
- R5: Bit-test class (op 4) loads V from mem_operand bit 6 and N from mem_operand bit 7. Z is set when alu_result is zero. C keeps its value.
- R6: Commands set or clear a single flag and leave the others unchanged. The codes are: 6 set C, 7 clear C, 8 set I, 9 clear I, 10 set D, 11 clear D, 12 set T, 13 clear T, 14 clear V.
- R7: Bit 4 (B) of the live flag byte always reads 0, including after a stack pull with that bit set.
- R8: An entry cycle (irq_take or brk_take high) leaves I at 1 after the edge. This overrides a clear of I in the same cycle, while other flags still follow the operation.
- R9: The pushed byte equals the live flags with bit 4 replaced by brk_take. With PUSH_REG=0 it is valid during the entry cycle. With PUSH_REG=1 it holds the byte captured at the last entry edge.
- R10: Pull class (op 5) loads every flag from pull_data except B, which stays 0.
- R11: irq_mask equals the I flag.
- R12: With HAS_T=0 the T bit reads 0 at all times, and the set-T command has no effect.
- R13: With op_valid low, or with the unused code 15 or code 0, the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation-class strobe |
| op_sel | input | 4 | Operation-class code |
| alu_result | input | DW | ALU or transfer result byte |
| alu_carry | input | 1 | ALU carry/borrow out |
| alu_ovf | input | 1 | ALU signed overflow |
| mem_operand | input | DW | Memory operand for bit test |
| pull_data | input | DW | Byte pulled from the stack |
| irq_take | input | 1 | Hardware interrupt accepted |
| brk_take | input | 1 | BRK entry |
| flags_q | output | DW | Live flag byte |
| push_byte | output | DW | Status byte to push |
| irq_mask | output | 1 | Interrupt mask (I flag) |

## Verification
The bench builds two copies that take the same stimulus. The first copy uses the default PUSH_REG=0 and HAS_T=1. It covers the pushed byte as it appears during the entry cycle, and it covers every T command. The second copy uses PUSH_REG=1 and HAS_T=0. In that copy the captured push byte can be checked as it holds across later non-entry cycles. A pull of 0xFF and a set-T command in that copy show that the T bit is gone.

// File: rtl/psr_pkg.sv
package psr_pkg;
   localparam int POS_C = 0;
   localparam int POS_Z = 1;
   localparam int POS_I = 2;
   localparam int POS_D = 3;
   localparam int POS_B = 4;
   localparam int POS_T = 5;
   localparam int POS_V = 6;
   localparam int POS_N = 7;

   typedef enum logic [3:0] {
      OPC_NONE  = 4'd0,
      OPC_ARITH = 4'd1,
      OPC_XFER  = 4'd2,
      OPC_SHIFT = 4'd3,
      OPC_BITT  = 4'd4,
      OPC_PULL  = 4'd5,
      OPC_SETC  = 4'd6,
      OPC_CLRC  = 4'd7,
      OPC_SETI  = 4'd8,
      OPC_CLRI  = 4'd9,
      OPC_SETD  = 4'd10,
      OPC_CLRD  = 4'd11,
      OPC_SETT  = 4'd12,
      OPC_CLRT  = 4'd13,
      OPC_CLRV  = 4'd14,
      OPC_RSVD  = 4'd15
   } psr_op_e;
endpackage

// File: rtl/psr_next.sv
module psr_next
   import psr_pkg::*;
#(
   parameter int DW    = 8,
   parameter bit HAS_T = 1'b1
) (
   input  logic [DW-1:0] cur,
   input  logic          op_valid,
   input  psr_op_e       op,
   input  logic [DW-1:0] alu_result,
   input  logic          alu_carry,
   input  logic          alu_ovf,
   input  logic [DW-1:0] mem_operand,
   input  logic [DW-1:0] pull_data,
   input  logic          entry,
   output logic [DW-1:0] nxt
);
   localparam int MSB = DW - 1;
   logic [DW-1:0] raw;
   logic          res_zero;

   assign res_zero = ~|alu_result;

   always_comb begin
      raw = cur;
      if (op_valid) begin
         unique case (op)
            OPC_ARITH: begin
               raw[POS_C] = alu_carry;
               raw[POS_V] = alu_ovf;
               raw[POS_Z] = res_zero;
               raw[POS_N] = alu_result[MSB];
            end
            OPC_XFER: begin
               raw[POS_Z] = res_zero;
               raw[POS_N] = alu_result[MSB];
            end
            OPC_SHIFT: begin
               raw[POS_C] = alu_carry;
               raw[POS_Z] = res_zero;
               raw[POS_N] = alu_result[MSB];
            end
            OPC_BITT: begin
               raw[POS_V] = mem_operand[MSB-1];
               raw[POS_N] = mem_operand[MSB];
               raw[POS_Z] = res_zero;
            end
            OPC_PULL: raw = pull_data;
            OPC_SETC: raw[POS_C] = 1'b1;
            OPC_CLRC: raw[POS_C] = 1'b0;
            OPC_SETI: raw[POS_I] = 1'b1;
            OPC_CLRI: raw[POS_I] = 1'b0;
            OPC_SETD: raw[POS_D] = 1'b1;
            OPC_CLRD: raw[POS_D] = 1'b0;
            OPC_SETT: raw[POS_T] = 1'b1;
            OPC_CLRT: raw[POS_T] = 1'b0;
            OPC_CLRV: raw[POS_V] = 1'b0;
            default: ;
         endcase
      end
      raw[POS_B] = 1'b0;
      if (entry) raw[POS_I] = 1'b1;
   end

   generate
      if (HAS_T) begin : g_with_t
         assign nxt = raw;
      end else begin : g_no_t
         always_comb begin
            nxt        = raw;
            nxt[POS_T] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/psr_push_fmt.sv
module psr_push_fmt
   import psr_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] flags,
   input  logic          brk,
   output logic [DW-1:0] pushed
);
   always_comb begin
      pushed        = flags;
      pushed[POS_B] = brk;
   end
endmodule

// File: rtl/psr_flags.sv
module psr_flags
   import psr_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit PUSH_REG = 1'b0,
   parameter bit HAS_T    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [3:0]    op_sel,
   input  logic [DW-1:0] alu_result,
   input  logic          alu_carry,
   input  logic          alu_ovf,
   input  logic [DW-1:0] mem_operand,
   input  logic [DW-1:0] pull_data,
   input  logic          irq_take,
   input  logic          brk_take,
   output logic [DW-1:0] flags_q,
   output logic [DW-1:0] push_byte,
   output logic          irq_mask
);
   localparam logic [DW-1:0] RST_FLAGS = DW'(1) << POS_I;

   generate
      if (DW != 8) begin : g_bad_width
         $error("psr_flags: DW must be 8");
      end
   endgenerate

   logic          entry;
   logic [DW-1:0] nxt;
   logic [DW-1:0] fmt;
   psr_op_e       op;

   assign entry    = irq_take | brk_take;
   assign op       = psr_op_e'(op_sel);
   assign irq_mask = flags_q[POS_I];

   psr_next #(.DW(DW), .HAS_T(HAS_T)) u_next (
      .cur(flags_q), .op_valid(op_valid), .op(op),
      .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
      .mem_operand(mem_operand), .pull_data(pull_data),
      .entry(entry), .nxt(nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= RST_FLAGS;
      else        flags_q <= nxt;
   end

   psr_push_fmt #(.DW(DW)) u_fmt (
      .flags(flags_q), .brk(brk_take), .pushed(fmt)
   );

   generate
      if (PUSH_REG) begin : g_push_reg
         logic [DW-1:0] push_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     push_q <= '0;
            else if (entry) push_q <= fmt;
         end
         assign push_byte = push_q;

         p_push_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
            entry |=> push_byte[POS_B] == $past(brk_take));
         p_push_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !entry |=> $stable(push_byte));
      end else begin : g_push_comb
         assign push_byte = fmt;
      end

      if (!HAS_T) begin : g_t_check
         p_t_absent_r12: assert property (@(posedge clk) disable iff (!rst_n)
            flags_q[POS_T] == 1'b0);
      end
   endgenerate

   p_b_live_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[POS_B] == 1'b0);

   p_entry_sets_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> flags_q[POS_I]);

   p_idle_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !entry) |=> $stable(flags_q));

   p_bit_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 4'd4) |=> flags_q[7:6] == $past(mem_operand[7:6]));

   p_pull_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 4'd5 && !entry) |=>
         (flags_q[7:6] == $past(pull_data[7:6]) &&
          flags_q[3:0] == $past(pull_data[3:0])));
endmodule

// File: tb/psr_flags_bench.sv
module psr_flags_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op_sel = 4'd0;
   logic [7:0] alu_result = 8'd0;
   logic       alu_carry = 1'b0;
   logic       alu_ovf = 1'b0;
   logic [7:0] mem_operand = 8'd0;
   logic [7:0] pull_data = 8'd0;
   logic       irq_take = 1'b0;
   logic       brk_take = 1'b0;
   logic [7:0] flags_a, push_a, flags_b, push_b;
   logic       mask_a, mask_b;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   psr_flags #(.DW(8), .PUSH_REG(1'b0), .HAS_T(1'b1)) u_psr_flags (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
      .mem_operand(mem_operand), .pull_data(pull_data),
      .irq_take(irq_take), .brk_take(brk_take),
      .flags_q(flags_a), .push_byte(push_a), .irq_mask(mask_a)
   );

   psr_flags #(.DW(8), .PUSH_REG(1'b1), .HAS_T(1'b0)) u_psr_flags_alt (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
      .mem_operand(mem_operand), .pull_data(pull_data),
      .irq_take(irq_take), .brk_take(brk_take),
      .flags_q(flags_b), .push_byte(push_b), .irq_mask(mask_b)
   );

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0; irq_take = 1'b0; brk_take = 1'b0; op_sel = 4'd0;
   endtask

   task automatic do_op(logic [3:0] op, logic [7:0] res, logic c, logic v, logic [7:0] mem);
      op_valid = 1'b1; op_sel = op; alu_result = res;
      alu_carry = c; alu_ovf = v; mem_operand = mem;
      tick();
   endtask

   task automatic t_reset();
      chk("R1 flags", flags_a, 8'h04);
      chk("R1 alt flags", flags_b, 8'h04);
      chk("R11 mask", {7'd0, mask_a}, 8'h01);
   endtask

   task automatic t_setclr();
      do_op(4'd6, 8'h11, 1'b0, 1'b0, 8'h00); chk("R6 setC", flags_a, 8'h05);
      do_op(4'd10, 8'h11, 1'b0, 1'b0, 8'h00); chk("R6 setD", flags_a, 8'h0D);
      do_op(4'd12, 8'h11, 1'b0, 1'b0, 8'h00); chk("R6 setT", flags_a, 8'h2D);
      chk("R12 setT ignored", flags_b, 8'h0D);
      do_op(4'd9, 8'h11, 1'b0, 1'b0, 8'h00); chk("R6 clrI", flags_a, 8'h29);
      chk("R11 mask low", {7'd0, mask_a}, 8'h00);
      do_op(4'd7, 8'h11, 1'b0, 1'b0, 8'h00); chk("R6 clrC", flags_a, 8'h28);
      do_op(4'd11, 8'h11, 1'b0, 1'b0, 8'h00); chk("R6 clrD", flags_a, 8'h20);
      do_op(4'd13, 8'h11, 1'b0, 1'b0, 8'h00); chk("R6 clrT", flags_a, 8'h00);
      do_op(4'd8, 8'h11, 1'b0, 1'b0, 8'h00); chk("R6 setI", flags_a, 8'h04);
   endtask

   task automatic t_arith();
      do_op(4'd1, 8'h00, 1'b1, 1'b1, 8'h00); chk("R2 zero result", flags_a, 8'h47);
      do_op(4'd1, 8'h80, 1'b0, 1'b0, 8'h00); chk("R2 negative result", flags_a, 8'h84);
   endtask

   task automatic t_xfer();
      do_op(4'd1, 8'h80, 1'b1, 1'b1, 8'h00); chk("R2 carry ovf", flags_a, 8'hC5);
      do_op(4'd2, 8'h00, 1'b0, 1'b0, 8'h00); chk("R3 zero keeps C V", flags_a, 8'h47);
      do_op(4'd2, 8'h7F, 1'b0, 1'b0, 8'h00); chk("R3 positive", flags_a, 8'h45);
   endtask

   task automatic t_shift();
      do_op(4'd3, 8'h80, 1'b0, 1'b0, 8'h00); chk("R4 shift keeps V", flags_a, 8'hC4);
      do_op(4'd14, 8'h00, 1'b1, 1'b1, 8'h00); chk("R6 clrV", flags_a, 8'h84);
   endtask

   task automatic t_bit();
      do_op(4'd4, 8'h00, 1'b1, 1'b0, 8'h40); chk("R5 bit6 set", flags_a, 8'h46);
      do_op(4'd4, 8'h01, 1'b1, 1'b1, 8'h80); chk("R5 bit7 set", flags_a, 8'h84);
   endtask

   task automatic t_idle();
      op_valid = 1'b0; op_sel = 4'd6; alu_result = 8'h00; alu_carry = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R13 strobe low", flags_a, 8'h84);
      do_op(4'd15, 8'h00, 1'b1, 1'b1, 8'hFF); chk("R13 reserved code", flags_a, 8'h84);
      do_op(4'd0, 8'h00, 1'b1, 1'b1, 8'hFF); chk("R13 code 0", flags_a, 8'h84);
   endtask

   task automatic t_pull();
      pull_data = 8'hFF; do_op(4'd5, 8'h00, 1'b0, 1'b0, 8'h00);
      chk("R10 pull FF", flags_a, 8'hEF);
      chk("R7 B zero after pull", {7'd0, flags_a[4]}, 8'h00);
      chk("R12 pull FF no T", flags_b, 8'hCF);
      pull_data = 8'h10; do_op(4'd5, 8'h00, 1'b0, 1'b0, 8'h00);
      chk("R10 pull 10", flags_a, 8'h00);
      chk("R11 mask after pull", {7'd0, mask_a}, 8'h00);
   endtask

   task automatic t_entry();
      irq_take = 1'b1; #1;
      chk("R9 push irq comb", push_a, 8'h00);
      tick();
      chk("R8 irq sets I", flags_a, 8'h04);
      chk("R9 push irq reg", push_b, 8'h00);
      do_op(4'd9, 8'h00, 1'b0, 1'b0, 8'h00); chk("R6 clrI again", flags_a, 8'h00);
      brk_take = 1'b1; #1;
      chk("R9 push brk comb", push_a, 8'h10);
      tick();
      chk("R8 brk sets I", flags_a, 8'h04);
      chk("R7 live B zero", {7'd0, flags_a[4]}, 8'h00);
      chk("R9 push brk reg", push_b, 8'h10);
      do_op(4'd6, 8'h00, 1'b0, 1'b0, 8'h00);
      chk("R9 reg push holds", push_b, 8'h10);
      irq_take = 1'b1; do_op(4'd9, 8'h00, 1'b0, 1'b0, 8'h00);
      chk("R8 entry beats clrI", flags_a, 8'h05);
      chk("R9 push captured", push_b, 8'h05);
      irq_take = 1'b1; do_op(4'd7, 8'h00, 1'b0, 1'b0, 8'h00);
      chk("R8 entry with clrC", flags_a, 8'h04);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setclr();
      t_arith();
      t_xfer();
      t_shift();
      t_bit();
      t_idle();
      t_pull();
      t_entry();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule